// File: doc/BRIEF.md
# Compare-Match Wake-Up Timer Core

This block counts elapsed seconds in a binary up-counter and compares the count against a wake-up value loaded by a register interface. When the next count equals the loaded wake-up value, the block signals an interrupt. The time-out behaviour is chosen by a parameter. In looping mode the interrupt is a short pulse, and the counter returns to zero and keeps counting, so the interrupt repeats with a fixed period. In handshake mode the interrupt is held and the counter stops until the host cycles the debounced reset.

The design runs on one system clock. Two single-cycle enables pace it: a one-second tick advances the counter, and a fast tick (128 Hz in the intended system) times the end of the looping pulse. A debounced active-low reset clears the count and the wake-up value, and counting begins when that reset rises. Any write to the wake-up value restarts counting from zero. If no wake-up value has been written since counting began, the counter runs silently up to all-ones and stops there. A second parameter selects the interrupt pin polarity: open-drain style (low when active) or push-pull style (high when active).

Top module: `wake_timer_core`

## Requirements
- R1: While running, each cycle with `tick_sec` high advances `count_o` by exactly one at that clock edge. At any other time the count only holds or returns to zero.
- R2: While `rstn_db` is low, `count_o` and `wake_o` read zero from the next edge on, and ticks have no effect. Counting starts only after `rstn_db` goes from low to high. A `tick_sec` in the same cycle as that rise does not advance the count.
- R3: A write (`wr_en` high while `rstn_db` is high) loads `wake_o` with `wr_data`, clears `count_o` to zero and starts counting. The write takes priority over a `tick_sec`, or a match, in the same cycle. A write while `rstn_db` is low is ignored.
- R4: With no write since counting started, no interrupt is produced. The counter stops at all-ones and holds there through further ticks.
- R5: From that stopped state, counting resumes from zero after either a write or a low-to-high transition of `rstn_db`.
- R6: Looping mode (`HANDSHAKE`=0): a tick whose next count equals `wake_o`, after a write, sets `count_o` to zero and asserts the interrupt at the same edge. The interrupt is released at the edge of the first later cycle with `tick_fast` high. With wake value w, the interrupt therefore recurs every w ticks.
- R7: Handshake mode (`HANDSHAKE`=1): a match sets `count_o` to the matched value and stops counting, and asserts the interrupt. The interrupt stays asserted through `rstn_db` low. It is released, and counting restarts, at the edge where `rstn_db` rises.
- R8: With `PUSH_PULL`=0, `irq_pin_o` is 0 when the interrupt is active and 1 when idle. With `PUSH_PULL`=1, the polarity is inverted.
- R9: A written wake value of zero never matches. The counter saturates at all-ones and stops, and no interrupt is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| rstn_db | input | 1 | Debounced active-low timer reset |
| tick_sec | input | 1 | One-cycle enable, once per second |
| tick_fast | input | 1 | One-cycle enable that ends the looping pulse |
| wr_en | input | 1 | Wake-up value write strobe |
| wr_data | input | CNT_W | Wake-up value to load |
| count_o | output | CNT_W | Live counter value |
| wake_o | output | CNT_W | Loaded wake-up value |
| irq_pin_o | output | 1 | Interrupt pin drive, polarity set by PUSH_PULL |

## Verification
Two functions collide when a write arrives in the same cycle as a one-second tick, and in particular in the cycle whose tick would complete a match. The bench provokes this on purpose. It first brings the count to one short of the wake value, then drives `wr_en` and `tick_sec` together. It expects the count to be zero, the new wake value to be loaded, and no interrupt on either mode variant. Exactly the new wake value's number of ticks must then pass before the next interrupt. A second collision, a pulse-ending fast tick against the start of a new pulse, is settled by giving the match priority.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    // Action applied to the counter and wake-up register in one cycle.
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_LOAD,
        ACT_START,
        ACT_STEP
    } cnt_act_e;

    // Control state carried next to the count.
    typedef struct packed {
        logic run;    // counter advances on second ticks
        logic armed;  // a wake-up value was written since the last reset
    } cnt_ctl_t;

    // Priority: timer reset, then write, then reset release, then tick.
    function automatic cnt_act_e pick_action(input logic rstn_db,
                                             input logic wr_en,
                                             input logic rise,
                                             input logic step);
        if (!rstn_db)
            return ACT_CLEAR;
        else if (wr_en)
            return ACT_LOAD;
        else if (rise)
            return ACT_START;
        else if (step)
            return ACT_STEP;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/wtc_rise.sv
module wtc_rise (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_o
);
    logic din_q;

    always_ff @(posedge clk) begin
        if (rst)
            din_q <= 1'b0;
        else
            din_q <= din;
    end

    assign rise_o = din & ~din_q;

    // A release is a single-cycle event.
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/wtc_counter.sv
module wtc_counter
    import wtc_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter bit HANDSHAKE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rstn_db,
    input  logic             rise,
    input  logic             tick_sec,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] wake_o,
    output logic             match_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] ZERO     = '0;

    logic [CNT_W-1:0] count_q, wake_q, count_nx;
    cnt_ctl_t         ctl_q;
    cnt_act_e         act;
    logic             hit;

    assign count_nx = count_q + 1'b1;
    assign hit      = ctl_q.armed && (count_nx == wake_q);
    assign act      = pick_action(rstn_db, wr_en, rise, ctl_q.run & tick_sec);
    assign match_o  = (act == ACT_STEP) && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= ZERO;
            wake_q  <= ZERO;
            ctl_q   <= '0;
        end else begin
            case (act)
                ACT_CLEAR: begin
                    count_q <= ZERO;
                    wake_q  <= ZERO;
                    ctl_q   <= '0;
                end
                ACT_LOAD: begin
                    count_q     <= ZERO;
                    wake_q      <= wr_data;
                    ctl_q.run   <= 1'b1;
                    ctl_q.armed <= 1'b1;
                end
                ACT_START: begin
                    count_q   <= ZERO;
                    ctl_q.run <= 1'b1;
                end
                ACT_STEP: begin
                    if (hit) begin
                        count_q   <= HANDSHAKE ? count_nx : ZERO;
                        ctl_q.run <= !HANDSHAKE;
                    end else begin
                        count_q <= count_nx;
                        if (count_nx == ALL_ONES)
                            ctl_q.run <= 1'b0;
                    end
                end
                default: begin
                    count_q <= count_q;
                end
            endcase
        end
    end

    assign count_o = count_q;
    assign wake_o  = wake_q;

    assert_step_or_clear_R1: assert property (@(posedge clk) disable iff (rst)
        rstn_db |=> (count_o == $past(count_o) ||
                     count_o == $past(count_o) + 1'b1 ||
                     count_o == ZERO));

    assert_hold_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
        !rstn_db |=> (count_o == ZERO && wake_o == ZERO));

    assert_write_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (rstn_db && wr_en) |=> (count_o == ZERO && wake_o == $past(wr_data)));

    assert_freeze_R4: assert property (@(posedge clk) disable iff (rst)
        (rstn_db && !wr_en && !rise && count_o == ALL_ONES) |=> count_o == ALL_ONES);

endmodule

// File: rtl/wtc_irq.sv
module wtc_irq #(
    parameter bit HANDSHAKE = 1'b0,
    parameter bit PUSH_PULL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic rstn_db,
    input  logic rise,
    input  logic tick_fast,
    input  logic match,
    output logic irq_pin_o
);
    logic pulse_q;   // looping-mode pulse
    logic latch_q;   // handshake-mode level
    logic active;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            // A new match wins over a pulse-ending fast tick.
            if (match && !HANDSHAKE)
                pulse_q <= 1'b1;
            else if (tick_fast || !rstn_db)
                pulse_q <= 1'b0;

            if (match && HANDSHAKE)
                latch_q <= 1'b1;
            else if (rise)
                latch_q <= 1'b0;
        end
    end

    assign active = pulse_q | latch_q;

    generate
        if (PUSH_PULL) begin : g_push_pull
            assign irq_pin_o = active;
        end else begin : g_open_drain
            assign irq_pin_o = ~active;
        end
    endgenerate

    generate
        if (HANDSHAKE) begin : g_hs_chk
            assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
                (latch_q && !rise) |=> latch_q);
            assert_latch_release_R7: assert property (@(posedge clk) disable iff (rst)
                rise |=> !latch_q);
        end else begin : g_loop_chk
            assert_pulse_end_R6: assert property (@(posedge clk) disable iff (rst)
                (pulse_q && tick_fast && !match) |=> !pulse_q);
            assert_pulse_start_R6: assert property (@(posedge clk) disable iff (rst)
                match |=> pulse_q);
        end
    endgenerate

endmodule

// File: rtl/wake_timer_core.sv
module wake_timer_core #(
    parameter int CNT_W     = 24,
    parameter bit HANDSHAKE = 1'b0,
    parameter bit PUSH_PULL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rstn_db,
    input  logic             tick_sec,
    input  logic             tick_fast,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] wake_o,
    output logic             irq_pin_o
);
    logic rise;
    logic match;

    wtc_rise i_rise (
        .clk    (clk),
        .rst    (rst),
        .din    (rstn_db),
        .rise_o (rise)
    );

    wtc_counter #(
        .CNT_W     (CNT_W),
        .HANDSHAKE (HANDSHAKE)
    ) i_counter (
        .clk      (clk),
        .rst      (rst),
        .rstn_db  (rstn_db),
        .rise     (rise),
        .tick_sec (tick_sec),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .count_o  (count_o),
        .wake_o   (wake_o),
        .match_o  (match)
    );

    wtc_irq #(
        .HANDSHAKE (HANDSHAKE),
        .PUSH_PULL (PUSH_PULL)
    ) i_irq (
        .clk       (clk),
        .rst       (rst),
        .rstn_db   (rstn_db),
        .rise      (rise),
        .tick_fast (tick_fast),
        .match     (match),
        .irq_pin_o (irq_pin_o)
    );

endmodule

// File: tb/test_wake_timer_core.sv
`timescale 1ns/1ps
module test_wake_timer_core;
    localparam int W = 4;
    localparam int TOP = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rn = 1'b0;
    logic sec = 1'b0, fast = 1'b0, wr = 1'b0;
    logic [W-1:0] wd = '0;
    logic [W-1:0] cnt_l, wake_l, cnt_h, wake_h;
    logic pin_l, pin_h;
    int runs = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Looping mode, open-drain polarity.
    wake_timer_core #(.CNT_W(W), .HANDSHAKE(1'b0), .PUSH_PULL(1'b0)) i_wake_timer_core (
        .clk(clk), .rst(rst), .rstn_db(rn), .tick_sec(sec), .tick_fast(fast),
        .wr_en(wr), .wr_data(wd), .count_o(cnt_l), .wake_o(wake_l), .irq_pin_o(pin_l));

    // Handshake mode, push-pull polarity.
    wake_timer_core #(.CNT_W(W), .HANDSHAKE(1'b1), .PUSH_PULL(1'b1)) i_wake_timer_core_hs (
        .clk(clk), .rst(rst), .rstn_db(rn), .tick_sec(sec), .tick_fast(fast),
        .wr_en(wr), .wr_data(wd), .count_o(cnt_h), .wake_o(wake_h), .irq_pin_o(pin_h));

    task automatic check(input string tag, input int act, input int exp);
        runs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, clock it, sample 1 ns after the edge.
    task automatic cyc(input logic s, input logic f, input logic w, input int d);
        sec = s; fast = f; wr = w; wd = W'(d);
        @(posedge clk);
        #1;
        sec = 1'b0; fast = 1'b0; wr = 1'b0;
    endtask

    task automatic reset_pulse();
        rn = 1'b0; cyc(0, 0, 0, 0);
        rn = 1'b1; cyc(0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cyc(0, 0, 0, 0);
        check("R2 reset count", cnt_l, 0);
        check("R2 reset wake", wake_h, 0);
        check("R8 open-drain idle high", pin_l, 1);
        check("R8 push-pull idle low", pin_h, 0);

        // Ticks and writes while the timer reset is low.
        cyc(1, 0, 0, 0);
        cyc(0, 0, 1, 9);
        check("R2 no count while low", cnt_l, 0);
        check("R3 write ignored while low", wake_l, 0);

        // Release with a tick in the same cycle.
        rn = 1'b1;
        cyc(1, 0, 0, 0);
        check("R2 no step on rise cycle", cnt_l, 0);

        // Unarmed run to saturation.
        for (int k = 1; k <= TOP + 4; k++) begin
            cyc(1, 0, 0, 0);
            check("R1 step / R4 saturate loop", cnt_l, (k < TOP) ? k : TOP);
            check("R1 step / R4 saturate hs", cnt_h, (k < TOP) ? k : TOP);
            check("R4 no irq loop", pin_l, 1);
            check("R4 no irq hs", pin_h, 0);
        end

        // Restart from the frozen state by a write of zero, with a tick.
        cyc(1, 0, 1, 0);
        check("R5 R3 write restarts count", cnt_l, 0);
        cyc(1, 0, 0, 0);
        check("R5 counting after write", cnt_l, 1);
        for (int k = 2; k <= TOP + 3; k++) begin
            cyc(1, 0, 0, 0);
            check("R9 zero wake saturates", cnt_h, (k < TOP) ? k : TOP);
            check("R9 zero wake no irq", pin_l, 1);
        end

        // Restart from the frozen state by a reset release.
        reset_pulse();
        check("R5 count zero after release", cnt_l, 0);
        cyc(1, 0, 0, 0);
        check("R5 counting after release", cnt_l, 1);

        // Sweep all nonzero wake values.
        for (int w = 1; w <= TOP; w++) begin
            rn = 1'b0; cyc(0, 0, 0, 0);
            check("R2 count cleared", cnt_h, 0);
            if (w > 1) check("R7 irq held through reset low", pin_h, 1);
            rn = 1'b1; cyc(0, 0, 0, 0);
            check("R7 released on rise", pin_h, 0);
            cyc(0, 0, 1, w);
            check("R3 wake loaded", wake_l, w);
            check("R3 count cleared by write", cnt_l, 0);
            for (int k = 1; k <= 2 * w + 1; k++) begin
                cyc(1, 0, 0, 0);
                check("R6 loop count", cnt_l, k % w);
                check("R6 loop pulse", pin_l, (k % w == 0) ? 0 : 1);
                check("R7 hs count", cnt_h, (k < w) ? k : w);
                check("R7 hs level", pin_h, (k >= w) ? 1 : 0);
                if (k % w == 0) begin
                    cyc(0, 1, 0, 0);
                    check("R6 pulse ends on fast tick", pin_l, 1);
                    check("R6 count holds on fast tick", cnt_l, 0);
                end
            end
        end

        // A write collides with the tick that would have matched.
        reset_pulse();
        cyc(0, 0, 1, 3);
        cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 0);
        check("R1 pre-collision count", cnt_l, 2);
        cyc(1, 0, 1, 5);
        check("R3 collision count loop", cnt_l, 0);
        check("R3 collision count hs", cnt_h, 0);
        check("R3 collision wake", wake_l, 5);
        check("R3 collision no pulse", pin_l, 1);
        check("R3 collision no level", pin_h, 0);
        for (int k = 1; k <= 5; k++) begin
            cyc(1, 0, 0, 0);
            check("R6 after collision loop pulse", pin_l, (k == 5) ? 0 : 1);
            check("R7 after collision hs level", pin_h, (k == 5) ? 1 : 0);
        end
        // Further ticks do not move the stopped handshake count.
        cyc(1, 0, 0, 0);
        check("R7 hs count frozen", cnt_h, 5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            runs++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

endmodule